// File: doc/BRIEF.md
# Macro Result Dispatcher

This block carries out the final step of each instruction in a small command-macro sequencer. For every instruction it receives three things from the sequencer: a 3-bit result mode, a destination register index and a 32-bit result. It then does some of the following in a single accepted cycle:
- write the destination register, either with the result or with a parameter popped from the input queue;
- reload the method word;
- issue a method send toward the engine.

The method word holds two fields. The low 12 bits are the method address. The next 6 bits are a step that is added to the address after every send.

The sequencer offers an instruction with `in_valid`. It treats `in_ready` as the permission to move on. A mode that needs a parameter is held off while the queue is empty, so the sequencer stalls there. A separate pass-through read port lets the sequencer's read instruction fetch an engine method register.

Top module: `macro_result_dispatch`

## Requirements
- R1: After reset, `rf_we`, `snd_valid` and `pq_pop` are low, and the method word (address and step) is zero. A send with no reload in between therefore goes to address 0, and the address stays at 0.
- R2: Mode 0 writes the popped parameter to the destination. Mode 1 writes the result. Neither mode sends or changes the method word.
- R3: Mode 2 writes the result, and mode 5 writes the popped parameter. Both load the method word from result bits 17:0: address = result[11:0], step = result[17:12]. Neither sends.
- R4: Mode 4 writes the result, and mode 3 writes the popped parameter. Both send the full result to the current method address.
- R5: Mode 6 writes the result and loads the method word from it. It then sends the popped parameter to address result[11:0].
- R6: Mode 7 writes the result and loads the method word from it. It then sends result[17:12], zero-extended to 32 bits, to address result[11:0].
- R7: After every send, the method address becomes the send address plus the current step, modulo 4096.
- R8: When a parameter-using mode (0, 3, 5, 6) is offered and `pq_valid` is low, `in_ready` is low. Nothing is then popped, written or sent, and the method word is unchanged. All other modes are always ready.
- R9: `pq_pop` is high, combinationally in the accept cycle, exactly when a parameter-using mode is accepted.
- R10: A write whose destination is register 0 is suppressed (`rf_we` stays low). All other effects of the mode still happen.
- R11: The write and send outputs are registered. They appear in the cycle after acceptance and last one cycle.
- R12: The read port forwards `rd_req` and `rd_method` to `eng_rd_en` and `eng_rd_addr`, and returns `eng_rd_data` on `rd_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction result offered |
| in_ready | output | 1 | Result accepted this cycle when `in_valid` is high |
| in_mode | input | 3 | Result mode 0..7 |
| in_dst | input | 3 | Destination register index |
| in_result | input | 32 | Instruction result |
| pq_valid | input | 1 | Parameter queue holds an entry |
| pq_data | input | 32 | Head of the parameter queue |
| pq_pop | output | 1 | Consume the queue head |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| snd_valid | output | 1 | Method send strobe |
| snd_addr | output | 12 | Method address of the send |
| snd_data | output | 32 | Method send data |
| rd_req | input | 1 | Sequencer read request |
| rd_method | input | 12 | Method register to read |
| rd_data | output | 32 | Read data back to the sequencer |
| eng_rd_en | output | 1 | Read strobe to the engine |
| eng_rd_addr | output | 12 | Read address to the engine |
| eng_rd_data | input | 32 | Read data from the engine |

## Verification
The bench builds the block with its defaults: a 32-bit data path, a 12-bit method address, a 6-bit step and 8 registers. This puts the 4096 address wrap within a few sends of a directed start near the top of the address space. It also lets random results pick up every step value from 0 to 63. Random queue availability combines stalls with all eight modes and with destination 0, and a bench model of the method word tracks every reload and advance.

// File: rtl/macro_disp_pkg.sv
// Package: shared types for the macro result dispatcher.
// Assumes result modes are encoded 0..7 as listed in res_mode_e.
package macro_disp_pkg;

    // Result modes of the dispatcher, encoding fixed by the instruction word.
    typedef enum logic [2:0] {
        RM_FETCH          = 3'd0,
        RM_MOVE           = 3'd1,
        RM_MOVE_LOAD      = 3'd2,
        RM_FETCH_SEND     = 3'd3,
        RM_MOVE_SEND      = 3'd4,
        RM_FETCH_LOAD     = 3'd5,
        RM_MOVE_LOAD_SENDP = 3'd6,
        RM_MOVE_LOAD_SENDS = 3'd7
    } res_mode_e;

    // Source of the data carried by a send.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RESULT = 2'd1,
        SRC_PARAM  = 2'd2,
        SRC_STEP   = 2'd3
    } snd_src_e;

    // Decoded control of one result mode.
    typedef struct packed {
        logic     fetch;     // pops a parameter; it becomes the write data
        logic     load;      // reloads the method word from the result
        snd_src_e snd_src;   // what a send carries, SRC_NONE for no send
    } res_ctl_t;

endpackage

// File: rtl/mrd_decode.sv
// Module: mrd_decode
// Turns a 3-bit result mode into the control bundle for the dispatcher.
// Assumes: purely combinational, every encoding is defined.
module mrd_decode
    import macro_disp_pkg::*;
(
    input  logic [2:0] mode,
    output res_ctl_t   ctl
);

    // Map each mode to its fetch / load / send behaviour.
    always_comb begin
        ctl = '{fetch: 1'b0, load: 1'b0, snd_src: SRC_NONE};
        case (res_mode_e'(mode))
            RM_FETCH:           ctl.fetch = 1'b1;
            RM_MOVE:            ;
            RM_MOVE_LOAD:       ctl.load = 1'b1;
            RM_FETCH_SEND: begin
                ctl.fetch   = 1'b1;
                ctl.snd_src = SRC_RESULT;
            end
            RM_MOVE_SEND:       ctl.snd_src = SRC_RESULT;
            RM_FETCH_LOAD: begin
                ctl.fetch = 1'b1;
                ctl.load  = 1'b1;
            end
            RM_MOVE_LOAD_SENDP: begin
                ctl.fetch   = 1'b0;
                ctl.load    = 1'b1;
                ctl.snd_src = SRC_PARAM;
            end
            RM_MOVE_LOAD_SENDS: begin
                ctl.load    = 1'b1;
                ctl.snd_src = SRC_STEP;
            end
            default:            ;
        endcase
        // Mode 6 pops the parameter for the send, but writes the result.
    end

endmodule

// File: rtl/mrd_method_unit.sv
// Module: mrd_method_unit
// Holds the method word (address + post-send step) and works out the
// address of the current send.
// Assumes: STEP_W <= ADDR_W; the address wraps modulo 2**ADDR_W.
module mrd_method_unit #(
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    localparam int WORD_W = ADDR_W + STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              load,
    input  logic              send,
    input  logic [WORD_W-1:0] new_word,
    output logic [ADDR_W-1:0] send_addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [STEP_W-1:0] eff_step;
    logic [ADDR_W-1:0] next_addr;

    // Pick the freshly loaded word or the held one for this instruction.
    always_comb begin
        eff_addr  = load ? new_word[ADDR_W-1:0]      : addr_q;
        eff_step  = load ? new_word[WORD_W-1:ADDR_W] : step_q;
        send_addr = eff_addr;
        next_addr = send ? eff_addr + ADDR_W'(eff_step) : eff_addr;
    end

    // Update the method word on every accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (accept) begin
            addr_q <= next_addr;
            step_q <= eff_step;
        end
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(addr_q) && $stable(step_q)));  // R8

    AST_SEND_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && send) |=> (addr_q == $past(send_addr) + ADDR_W'(step_q)));  // R7

endmodule

// File: rtl/mrd_out_stage.sv
// Module: mrd_out_stage
// Registers the register-file write and the method send of an accepted
// instruction, so both appear one cycle later as one-cycle pulses.
// Assumes: register index 0 is a constant-zero register and is never written.
module mrd_out_stage
    import macro_disp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  res_ctl_t          ctl,
    input  logic [IDX_W-1:0]  dst,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] param,
    input  logic [ADDR_W-1:0] send_addr,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              snd_valid,
    output logic [ADDR_W-1:0] snd_addr,
    output logic [DATA_W-1:0] snd_data
);

    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] snd_val;
    logic              wr_en;
    logic              snd_en;

    // Choose write and send payloads for the current instruction.
    always_comb begin
        wr_val = ctl.fetch ? param : result;
        wr_en  = accept && (dst != '0);
        snd_en = accept && (ctl.snd_src != SRC_NONE);
        case (ctl.snd_src)
            SRC_PARAM: snd_val = param;
            SRC_STEP:  snd_val = DATA_W'(result[ADDR_W+STEP_W-1:ADDR_W]);
            default:   snd_val = result;
        endcase
    end

    // Capture the payloads; strobes drop after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we     <= 1'b0;
            rf_waddr  <= '0;
            rf_wdata  <= '0;
            snd_valid <= 1'b0;
            snd_addr  <= '0;
            snd_data  <= '0;
        end else begin
            rf_we     <= wr_en;
            snd_valid <= snd_en;
            if (wr_en) begin
                rf_waddr <= dst;
                rf_wdata <= wr_val;
            end
            if (snd_en) begin
                snd_addr <= send_addr;
                snd_data <= snd_val;
            end
        end
    end

    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != '0));  // R10

    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(accept));  // R11

    AST_SEND_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        snd_valid |-> $past(accept));  // R11

endmodule

// File: rtl/macro_result_dispatch.sv
// Module: macro_result_dispatch (top)
// Result step of a command-macro sequencer: register write, parameter pop,
// method-word reload and method send, plus a pass-through engine read port.
// Assumes: the parameter queue presents its head on pq_data while pq_valid.
module macro_result_dispatch
    import macro_disp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_mode,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic [DATA_W-1:0] in_result,
    input  logic              pq_valid,
    input  logic [DATA_W-1:0] pq_data,
    output logic              pq_pop,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              snd_valid,
    output logic [ADDR_W-1:0] snd_addr,
    output logic [DATA_W-1:0] snd_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_method,
    output logic [DATA_W-1:0] rd_data,
    output logic              eng_rd_en,
    output logic [ADDR_W-1:0] eng_rd_addr,
    input  logic [DATA_W-1:0] eng_rd_data
);

    res_ctl_t          ctl;
    logic              accept;
    logic              send;
    logic [ADDR_W-1:0] send_addr;

    mrd_decode u_decode (
        .mode (in_mode),
        .ctl  (ctl)
    );

    // Handshake: parameter-using modes wait for a queue entry.
    always_comb begin
        send     = (ctl.snd_src != SRC_NONE);
        in_ready = !(ctl.fetch || ctl.snd_src == SRC_PARAM) || pq_valid;
        accept   = in_valid && in_ready;
        pq_pop   = accept && (ctl.fetch || ctl.snd_src == SRC_PARAM);
    end

    mrd_method_unit #(
        .ADDR_W (ADDR_W),
        .STEP_W (STEP_W)
    ) u_method (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .load      (ctl.load),
        .send      (send),
        .new_word  (in_result[ADDR_W+STEP_W-1:0]),
        .send_addr (send_addr)
    );

    mrd_out_stage #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .STEP_W (STEP_W),
        .IDX_W  (IDX_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .ctl       (ctl),
        .dst       (in_dst),
        .result    (in_result),
        .param     (pq_data),
        .send_addr (send_addr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .snd_valid (snd_valid),
        .snd_addr  (snd_addr),
        .snd_data  (snd_data)
    );

    // Engine read port is a straight pass-through for the read instruction.
    always_comb begin
        eng_rd_en   = rd_req;
        eng_rd_addr = rd_method;
        rd_data     = eng_rd_data;
    end

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pq_pop |-> (pq_valid && in_valid));  // R9

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (!rf_we && !snd_valid));  // R8

endmodule

// File: tb/macro_result_dispatch_bench.sv
module macro_result_dispatch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_mode = '0;
    logic [2:0]  in_dst = '0;
    logic [31:0] in_result = '0;
    logic        pq_valid = 1'b0;
    logic [31:0] pq_data = '0;
    logic        pq_pop;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        snd_valid;
    logic [11:0] snd_addr;
    logic [31:0] snd_data;
    logic        rd_req = 1'b0;
    logic [11:0] rd_method = '0;
    logic [31:0] rd_data;
    logic        eng_rd_en;
    logic [11:0] eng_rd_addr;
    logic [31:0] eng_rd_data = '0;

    int unsigned n_tests = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    logic [11:0] m_addr = '0;
    logic [5:0]  m_step = '0;

    always #2.5 clk = ~clk;

    macro_result_dispatch u_macro_result_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_dst(in_dst), .in_result(in_result),
        .pq_valid(pq_valid), .pq_data(pq_data), .pq_pop(pq_pop),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .snd_valid(snd_valid), .snd_addr(snd_addr), .snd_data(snd_data),
        .rd_req(rd_req), .rd_method(rd_method), .rd_data(rd_data),
        .eng_rd_en(eng_rd_en), .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit uses_param(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd3) || (m == 3'd5) || (m == 3'd6);
    endfunction

    function automatic bit loads(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd5) || (m == 3'd6) || (m == 3'd7);
    endfunction

    function automatic bit sends(input logic [2:0] m);
        return (m == 3'd3) || (m == 3'd4) || (m == 3'd6) || (m == 3'd7);
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [2:0] m, input logic [31:0] r, input logic [31:0] p);
        return (m == 3'd0 || m == 3'd3 || m == 3'd5) ? p : r;
    endfunction

    function automatic logic [31:0] exp_sdata(input logic [2:0] m, input logic [31:0] r, input logic [31:0] p);
        if (m == 3'd6) return p;
        if (m == 3'd7) return {26'd0, r[17:12]};
        return r;
    endfunction

    // One instruction offer: drive at the falling edge, check handshake,
    // then check the registered outputs one cycle later.
    task automatic step(input logic [2:0] m, input logic [2:0] d, input logic [31:0] r,
                        input bit v, input bit pv, input logic [31:0] pd);
        bit          need, acc, snd;
        logic [11:0] ea;
        logic [5:0]  es;
        in_mode = m; in_dst = d; in_result = r; in_valid = v;
        pq_valid = pv; pq_data = pd;
        #1;
        need = uses_param(m);
        acc  = v && (!need || pv);
        snd  = acc && sends(m);
        chk(in_ready == (!need || pv), "R8 in_ready", 32'(in_ready), 32'(!need || pv));
        chk(pq_pop == (acc && need), "R9 pq_pop", 32'(pq_pop), 32'(acc && need));
        ea = loads(m) ? r[11:0] : m_addr;
        es = loads(m) ? r[17:12] : m_step;
        @(posedge clk);
        @(negedge clk);
        chk(rf_we == (acc && d != 0), "R10/R11 rf_we", 32'(rf_we), 32'(acc && d != 0));
        if (acc && d != 0) begin
            chk(rf_waddr == d, "R2 rf_waddr", 32'(rf_waddr), 32'(d));
            chk(rf_wdata == exp_wdata(m, r, pd), "R2/R3/R4 rf_wdata", rf_wdata, exp_wdata(m, r, pd));
        end
        chk(snd_valid == snd, "R4/R8/R11 snd_valid", 32'(snd_valid), 32'(snd));
        if (snd) begin
            chk(snd_addr == ea, "R5/R7 snd_addr", 32'(snd_addr), 32'(ea));
            chk(snd_data == exp_sdata(m, r, pd), "R5/R6 snd_data", snd_data, exp_sdata(m, r, pd));
        end
        if (acc) begin
            m_addr = snd ? ea + 12'(es) : ea;
            m_step = es;
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk(rf_we == 1'b0, "R1 rf_we", 32'(rf_we), 0);
        chk(snd_valid == 1'b0, "R1 snd_valid", 32'(snd_valid), 0);
        chk(pq_pop == 1'b0, "R1 pq_pop", 32'(pq_pop), 0);
        @(negedge clk);
        // R1: send before any reload goes to address 0, and stays there
        step(3'd4, 3'd1, 32'hAAAA_0001, 1, 0, 0);
        step(3'd4, 3'd1, 32'hAAAA_0002, 1, 0, 0);
        // R3: mode 5 loads address 0xFFE, step 3 (bits 17:12)
        step(3'd5, 3'd2, 32'h0000_3FFE, 1, 1, 32'h1111_2222);
        // R7: wrap from 0xFFE through 0x001
        step(3'd4, 3'd3, 32'hDEAD_BEEF, 1, 0, 0);
        step(3'd3, 3'd3, 32'hCAFE_F00D, 1, 1, 32'h5555_AAAA);
        step(3'd4, 3'd3, 32'h0BAD_0BAD, 1, 0, 0);
        // R8: stall on empty queue for every parameter mode, then deliver
        step(3'd0, 3'd4, 32'h1, 1, 0, 32'h77);
        step(3'd3, 3'd4, 32'h2, 1, 0, 32'h77);
        step(3'd5, 3'd4, 32'h0003_F123, 1, 0, 32'h77);
        step(3'd6, 3'd4, 32'h0001_0100, 1, 0, 32'h77);
        step(3'd4, 3'd4, 32'h3, 1, 0, 0);
        step(3'd0, 3'd4, 32'h1, 1, 1, 32'h9999_0000);
        // R10: destination 0 keeps sends and reloads
        step(3'd7, 3'd0, 32'h0002_A050, 1, 0, 0);
        step(3'd1, 3'd0, 32'h1234_5678, 1, 0, 0);
        // R5/R6/R2: remaining modes
        step(3'd6, 3'd5, 32'h0004_0FFF, 1, 1, 32'hFACE_0001);
        step(3'd7, 3'd6, 32'hFFFF_FFFF, 1, 0, 0);
        step(3'd2, 3'd7, 32'h0000_0010, 1, 0, 0);
        step(3'd1, 3'd7, 32'h0000_0020, 1, 0, 0);
        // R11: idle cycle produces no pulse
        step(3'd4, 3'd1, 32'h0, 0, 0, 0);
        // R12: read port pass-through
        rd_req = 1'b1; rd_method = 12'hABC; eng_rd_data = 32'h0F0F_1234;
        #1;
        chk(eng_rd_en == 1'b1, "R12 eng_rd_en", 32'(eng_rd_en), 1);
        chk(eng_rd_addr == 12'hABC, "R12 eng_rd_addr", 32'(eng_rd_addr), 32'hABC);
        chk(rd_data == 32'h0F0F_1234, "R12 rd_data", rd_data, 32'h0F0F_1234);
        rd_req = 1'b0;
        #1;
        chk(eng_rd_en == 1'b0, "R12 eng_rd_en idle", 32'(eng_rd_en), 0);
        @(negedge clk);
        // Random mix of all modes, stalls and idles
        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), $urandom(),
                 ($urandom_range(0, 7) != 0), ($urandom_range(0, 2) != 0), $urandom());
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule